// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked system and an asynchronous static RAM of 512K bytes. It accepts one single-beat read or write at a time through a valid/ready handshake and turns it into the active-low chip select, output enable and write enable waveforms the memory needs. Every phase is a whole number of system clock cycles. Each phase length is a parameter, worked out as the nanosecond figure from the memory's timing table divided by the clock period and rounded up.

A read holds the address with chip select and output enable low until the slower of the address and output-enable access windows has run out. It then samples the data bus and returns it with a one-cycle valid pulse. A write places the whole write-enable low pulse inside a chip-select-low frame, so the address can never move while a write is in progress. The data driver is enabled only after the memory has had time to release the bus after a read, and write data stays on the bus one cycle after write enable rises. Between accesses chip select is high, which puts the memory in standby.

The data bus is split into an output value, an output enable and an input value, so that an external tri-state pad can be attached.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, mem_cs_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, req_ready is 1 and rd_valid is 0.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1, and req_ready is 0 in the cycle that follows. While req_ready is 0, req_valid, req_addr and req_wdata have no effect on mem_addr.
- R3: A read (req_write=0) keeps mem_cs_n=0, mem_oe_n=0 and mem_we_n=1 with mem_addr equal to the request address for exactly T_AA_CYC+1 cycles. After that, rd_valid is 1 for exactly one cycle, carrying the value of mem_dq_in sampled on the edge that ends the last of those cycles. In that same cycle req_ready is 1 again and mem_cs_n and mem_oe_n are 1.
- R4: A write (req_write=1) holds mem_we_n at 0 for exactly max(T_WP_CYC, T_DW_CYC) cycles. During that pulse mem_cs_n is 0, mem_oe_n is 1, mem_dq_oe is 1 and mem_dq_out equals the request data. mem_cs_n is 0 for at least one cycle before mem_we_n falls.
- R5: In the cycle after mem_we_n rises, mem_dq_oe stays 1 with mem_dq_out unchanged and mem_cs_n still 0. In the cycle after that, mem_cs_n is 1, mem_dq_oe is 0 and req_ready is 1.
- R6: mem_addr does not change during any cycle in which mem_cs_n was already 0 in the previous cycle.
- R7: After a read ends (mem_oe_n rises), mem_dq_oe stays 0 for at least T_HZ_CYC+1 cycles. When a write is accepted in the first cycle after a read, mem_dq_oe rises exactly T_HZ_CYC+2 cycles after the last cycle with mem_oe_n at 0.
- R8: Whenever mem_cs_n is 1, mem_oe_n and mem_we_n are 1 and mem_dq_oe is 0.
- R9: mem_oe_n and mem_we_n are never both 0, and mem_dq_oe is never 1 while mem_oe_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller can take a request |
| rd_data | output | DATA_W | Read result |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W | Data toward the pad driver |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_in | input | DATA_W | Data from the pad receiver |

## Verification
The bench builds the block with T_AA_CYC=2, T_WP_CYC=1, T_DW_CYC=2 and T_HZ_CYC=3, not with the 100 MHz defaults, where every window except access collapses to one cycle. Because T_DW_CYC is larger than T_WP_CYC, the data setup window sets the write pulse length, so the maximum rule is exercised. With T_HZ_CYC at 3, the turnaround wait after a read lasts longer than the single mandatory cycle before write enable, so a read followed at once by a write shows a stall of measurable length. Random address aliasing onto 64 model locations gives read-after-write hits at many distances.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ACCESS,
      ST_RD_CAPTURE,
      ST_WR_TURN,
      ST_WR_PULSE,
      ST_WR_RELEASE
   } asram_state_e;

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // a fresh nonzero load must not report expiry in the next cycle
   p_load_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/asram_hz_guard.sv
module asram_hz_guard #(
   parameter int T_HZ_CYC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic bus_quiet
);

   localparam int HZ_W = (T_HZ_CYC < 2) ? 1 : $clog2(T_HZ_CYC + 1);

   logic [HZ_W-1:0] hz_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hz_q <= '0;
      end else if (arm) begin
         hz_q <= HZ_W'(T_HZ_CYC);
      end else if (hz_q != '0) begin
         hz_q <= hz_q - 1'b1;
      end
   end

   assign bus_quiet = (hz_q == '0);

   // the memory may still drive right after output enable is released
   p_guard_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> !bus_quiet);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int DATA_W   = 8,
   parameter int T_AA_CYC = 2,
   parameter int T_WP_CYC = 1,
   parameter int T_DW_CYC = 1,
   parameter int T_HZ_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int PULSE_CYC = (T_WP_CYC > T_DW_CYC) ? T_WP_CYC : T_DW_CYC;
   localparam int TMR_MAX   = (T_AA_CYC > PULSE_CYC) ? T_AA_CYC : PULSE_CYC;
   localparam int TMR_W     = (TMR_MAX < 2) ? 1 : $clog2(TMR_MAX);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("asram_ctrl: ADDR_W and DATA_W must be positive");
      end
      if (T_AA_CYC < 1 || T_WP_CYC < 1 || T_DW_CYC < 1 || T_HZ_CYC < 1) begin : g_bad_phase
         $error("asram_ctrl: every phase length must be at least one cycle");
      end
   endgenerate

   localparam logic [TMR_W-1:0] AA_LOAD    = TMR_W'(T_AA_CYC - 1);
   localparam logic [TMR_W-1:0] PULSE_LOAD = TMR_W'(PULSE_CYC - 1);

   asram_state_e     state_q;
   logic             accept;
   logic             tmr_load;
   logic [TMR_W-1:0] tmr_val;
   logic             tmr_done;
   logic             hz_arm;
   logic             hz_quiet;

   assign accept = req_valid && req_ready;
   assign hz_arm = (state_q == ST_RD_CAPTURE);

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = AA_LOAD;
      case (state_q)
         ST_IDLE: begin
            tmr_load = accept;
            tmr_val  = AA_LOAD;
         end
         ST_WR_TURN: begin
            tmr_load = hz_quiet;
            tmr_val  = PULSE_LOAD;
         end
         default: begin
            tmr_load = 1'b0;
         end
      endcase
   end

   asram_phase_timer #(.CNT_W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   asram_hz_guard #(.T_HZ_CYC(T_HZ_CYC)) u_hz_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (hz_arm),
      .bus_quiet (hz_quiet)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         req_ready  <= 1'b1;
         rd_data    <= '0;
         rd_valid   <= 1'b0;
         mem_addr   <= '0;
         mem_cs_n   <= 1'b1;
         mem_oe_n   <= 1'b1;
         mem_we_n   <= 1'b1;
         mem_dq_out <= '0;
         mem_dq_oe  <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  mem_addr   <= req_addr;
                  mem_dq_out <= req_wdata;
                  mem_cs_n   <= 1'b0;
                  req_ready  <= 1'b0;
                  if (req_write) begin
                     state_q <= ST_WR_TURN;
                  end else begin
                     mem_oe_n <= 1'b0;
                     state_q  <= ST_RD_ACCESS;
                  end
               end
            end
            ST_RD_ACCESS: begin
               if (tmr_done) state_q <= ST_RD_CAPTURE;
            end
            ST_RD_CAPTURE: begin
               rd_data   <= mem_dq_in;
               rd_valid  <= 1'b1;
               req_ready <= 1'b1;
               mem_cs_n  <= 1'b1;
               mem_oe_n  <= 1'b1;
               state_q   <= ST_IDLE;
            end
            ST_WR_TURN: begin
               if (hz_quiet) begin
                  mem_we_n  <= 1'b0;
                  mem_dq_oe <= 1'b1;
                  state_q   <= ST_WR_PULSE;
               end
            end
            ST_WR_PULSE: begin
               if (tmr_done) begin
                  mem_we_n <= 1'b1;
                  state_q  <= ST_WR_RELEASE;
               end
            end
            ST_WR_RELEASE: begin
               mem_dq_oe <= 1'b0;
               mem_cs_n  <= 1'b1;
               req_ready <= 1'b1;
               state_q   <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   p_we_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));

   p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && !mem_cs_n && $stable(mem_dq_out)));

   p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

   p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !hz_quiet |-> !mem_dq_oe);

   p_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cs_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

   p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

   localparam int AW     = 19;
   localparam int DW     = 8;
   localparam int AA     = 2;
   localparam int WP     = 1;
   localparam int DWC    = 2;
   localparam int HZ     = 3;
   localparam int PULSE  = (WP > DWC) ? WP : DWC;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic [AW-1:0] mem_addr;
   logic          mem_cs_n, mem_oe_n, mem_we_n;
   logic [DW-1:0] mem_dq_out;
   logic          mem_dq_oe;
   logic [DW-1:0] mem_dq_in;

   logic [DW-1:0] model  [64];
   logic [DW-1:0] shadow [64];

   int cyc = 0;
   int n_tests = 0;
   int n_fail = 0;
   int last_oe_low = -1000;

   always #5 clk = ~clk;

   asram_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .T_AA_CYC(AA), .T_WP_CYC(WP),
      .T_DW_CYC(DWC), .T_HZ_CYC(HZ)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
      .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // memory model: drives only while selected and output-enabled
   assign mem_dq_in = (!mem_cs_n && !mem_oe_n) ? model[mem_addr[5:0]] : 8'hA5;

   always @(posedge clk) begin
      if (!mem_cs_n && !mem_we_n && mem_dq_oe) model[mem_addr[5:0]] <= mem_dq_out;
   end

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 60000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, actual cycle %0d expected < 60000", cyc);
         summary();
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests = n_tests + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // starts and ends just after a negedge with the controller idle
   task automatic do_read(input logic [AW-1:0] a, input bit hold);
      int n;
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 8'h3C;
      @(negedge clk);
      chk(!req_ready, "R2 ready low after accept", req_ready, 0);
      if (hold) begin
         req_addr = ~a; req_wdata = 8'hFF; req_write = 1'b1;
      end else begin
         req_valid = 1'b0;
      end
      n = 0;
      while (!rd_valid) begin
         chk(!mem_cs_n && !mem_oe_n && mem_we_n, "R3 read strobes",
             {mem_cs_n, mem_oe_n, mem_we_n}, 3'b001);
         chk(mem_addr == a, "R6 read address held", mem_addr, a);
         chk(!mem_dq_oe, "R9 no drive during read", mem_dq_oe, 0);
         if (hold) chk(mem_addr != ~a, "R2 busy request ignored", mem_addr, a);
         last_oe_low = cyc;
         n++;
         @(negedge clk);
      end
      req_valid = 1'b0;
      chk(n == AA + 1, "R3 access length", n, AA + 1);
      chk(rd_data == shadow[a[5:0]], "R3 read data", rd_data, shadow[a[5:0]]);
      chk(req_ready && mem_cs_n && mem_oe_n, "R3 release with valid",
          {req_ready, mem_cs_n, mem_oe_n}, 3'b111);
      @(negedge clk);
      chk(!rd_valid, "R3 single valid pulse", rd_valid, 0);
      chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R8 standby after read",
          {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input int exact_gap);
      int turn;
      int w;
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R2 ready low after accept", req_ready, 0);
      turn = 0;
      while (mem_we_n) begin
         chk(!mem_cs_n && !mem_dq_oe && mem_oe_n, "R7 turnaround quiet",
             {mem_cs_n, mem_dq_oe, mem_oe_n}, 3'b001);
         chk(mem_addr == a, "R6 write address held", mem_addr, a);
         turn++;
         @(negedge clk);
      end
      chk(turn >= 1, "R4 select before write enable", turn, 1);
      chk(cyc - last_oe_low >= HZ + 2, "R7 bus release window", cyc - last_oe_low, HZ + 2);
      if (exact_gap != 0) chk(cyc - last_oe_low == exact_gap, "R7 back-to-back gap",
                              cyc - last_oe_low, exact_gap);
      w = 0;
      while (!mem_we_n) begin
         chk(!mem_cs_n && mem_oe_n && mem_dq_oe, "R4 pulse frame",
             {mem_cs_n, mem_oe_n, mem_dq_oe}, 3'b011);
         chk(mem_dq_out == d, "R4 write data", mem_dq_out, d);
         chk(mem_addr == a, "R6 address during pulse", mem_addr, a);
         w++;
         @(negedge clk);
      end
      chk(w == PULSE, "R4 pulse length", w, PULSE);
      chk(mem_dq_oe && !mem_cs_n && mem_dq_out == d, "R5 data hold cycle",
          {mem_dq_oe, mem_cs_n}, 2'b10);
      @(negedge clk);
      chk(mem_cs_n && !mem_dq_oe && req_ready, "R5 write release",
          {mem_cs_n, mem_dq_oe, req_ready}, 3'b101);
      chk(mem_oe_n && mem_we_n, "R8 standby after write", {mem_oe_n, mem_we_n}, 2'b11);
      shadow[a[5:0]] = d;
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5EED_0042);
      for (int i = 0; i < 64; i++) begin
         model[i]  = '0;
         shadow[i] = '0;
      end
      repeat (3) @(negedge clk);
      chk(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes in reset",
          {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rd_valid,
          "R1 reset state",
          {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rd_valid}, 6'b111010);

      // directed corners
      do_write(19'h7FFFF, 8'hC3, 0);
      do_read(19'h7FFFF, 1'b0);
      do_write(19'h00000, 8'h5A, HZ + 2);      // accepted right after a read
      do_read(19'h00000, 1'b1);                // request held while busy
      do_write(19'h12345, 8'h00, HZ + 2);
      do_read(19'h12345, 1'b0);
      do_write(19'h12345, 8'hFF, HZ + 2);
      do_write(19'h12345, 8'h81, 0);           // write after write
      do_read(19'h12345, 1'b0);

      // constrained random mix
      for (int k = 0; k < 200; k++) begin
         logic [AW-1:0] a;
         int gap;
         a = AW'($urandom_range(0, 32'h7FFFF));
         gap = $urandom_range(0, 2);
         repeat (gap) @(negedge clk);
         if ($urandom_range(0, 1) == 1) do_write(a, DW'($urandom_range(0, 255)), 0);
         else do_read(a, ($urandom_range(0, 3) == 0));
      end
      summary();
   end

endmodule